// File: doc/BRIEF.md
# Debug Fault Address and Transfer Registers

This unit sits beside a processor core as part of its debug coprocessor. It decodes the core's coprocessor move requests and serves two kinds of state. The first is a 32-bit fault address register. When a watchpoint fires, it records where the offending instruction sits, plus the pipeline offset that the current instruction-set state implies. Software in a privileged mode may also read or reload it.

The second is a pair of one-way 32-bit transfer registers between the core and an external debugger. The core-to-debugger register is written by the core and read by the debugger. The debugger-to-core register works the other way round. Each has a full bit. A producer's write sets the bit. A consumer's read clears it. A producer write that arrives while the bit is set is dropped.

Every response to the core or to the debugger is registered. It appears one clock after the request cycle.

Top module: `dbg_xfer_regs`

## Requirements
- R1: A synchronous active-high reset clears the fault address register to 0 and clears both full flags.
- R2: A watchpoint strobe with state code 0 (32-bit instructions) loads the fault address register with the given instruction address plus 8.
- R3: A watchpoint strobe with state code 1 (16-bit instructions) loads the address plus 4.
- R4: A watchpoint strobe with state code 2 (bytecode) loads the address unchanged. Code 3 is treated the same way.
- R5: Data abort and prefetch abort strobes leave the fault address register unchanged.
- R6: A privileged request with op1=0, CRn=0, CRm=6, op2=0 reaches the fault address register. A read returns its value on the data output one cycle later, with the ack set. A write loads the request data.
- R7: A fault address register request made with the privilege input low sets the undefined output together with the ack, and leaves the register unchanged.
- R8: When a watchpoint strobe and a software write to the fault address register fall in the same cycle, the watchpoint value is the one stored.
- R9: A core write with op1=0, CRn=0, CRm=5, op2=0 loads the core-to-debugger register and sets its full flag. A debugger read (ext_write_i=0) returns that value one cycle later and clears the flag.
- R10: A debugger write (ext_write_i=1) loads the debugger-to-core register and sets its full flag. A core read with the CRm=5 encoding returns that value one cycle later and clears the flag.
- R11: A producer write to a transfer register whose full flag is set is ignored. The held data does not change.
- R12: Any other encoding gives an undefined response. Its read data is 0 and it changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wp_hit_i | input | 1 | Watchpoint hit strobe |
| wp_pc_i | input | 32 | Address of the instruction that hit |
| isa_state_i | input | 2 | Instruction-set state: 0 32-bit, 1 16-bit, 2 bytecode |
| dabort_i | input | 1 | Precise data abort strobe |
| pabort_i | input | 1 | Prefetch abort strobe |
| priv_i | input | 1 | Core is in a privileged mode |
| cp_valid_i | input | 1 | Coprocessor request valid |
| cp_read_i | input | 1 | 1 = move from coprocessor or store; 0 = move to coprocessor or load |
| cp_op1_i | input | 3 | Opcode 1 field |
| cp_crn_i | input | 4 | CRn field |
| cp_crm_i | input | 4 | CRm field |
| cp_op2_i | input | 3 | Opcode 2 field |
| cp_wdata_i | input | 32 | Core write data |
| cp_ack_o | output | 1 | Response valid, one cycle after the request |
| cp_undef_o | output | 1 | Request was rejected as undefined |
| cp_rdata_o | output | 32 | Core read data |
| ext_valid_i | input | 1 | Debugger request valid |
| ext_write_i | input | 1 | 1 = write the debugger-to-core register; 0 = read the core-to-debugger register |
| ext_wdata_i | input | 32 | Debugger write data |
| ext_ack_o | output | 1 | Debugger response valid |
| ext_rdata_o | output | 32 | Debugger read data |
| c2d_full_o | output | 1 | Core-to-debugger register holds unread data |
| d2c_full_o | output | 1 | Debugger-to-core register holds unread data |

## Verification
The hardest case to reach is a watchpoint capture and a software reload of the fault address register in the very same edge. A second hard case is a producer write that lands on a transfer register that is already full. For the first, the bench drives the watchpoint strobe and a privileged write request in one negative-edge slot. It then reads the register back to see which value won. For the full-flag case, the bench fills a register and leaves it unread. It then issues a second producer write and drains the register, which shows that the first value survived.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
  typedef enum logic [1:0] {
    ISA_A32 = 2'd0,
    ISA_T16 = 2'd1,
    ISA_BC  = 2'd2,
    ISA_RSV = 2'd3
  } isa_e;

  localparam logic [2:0] ENC_OP1     = 3'd0;
  localparam logic [3:0] ENC_CRN     = 4'd0;
  localparam logic [2:0] ENC_OP2     = 3'd0;
  localparam logic [3:0] ENC_CRM_FA  = 4'd6;
  localparam logic [3:0] ENC_CRM_XFR = 4'd5;
endpackage

// File: rtl/dbg_cp_decode.sv
module dbg_cp_decode (
  input  logic [2:0] op1,
  input  logic [3:0] crn,
  input  logic [3:0] crm,
  input  logic [2:0] op2,
  output logic       sel_fa,
  output logic       sel_xfr,
  output logic       unknown
);
  logic base_ok;

  always_comb begin
    base_ok = (op1 == dbg_pkg::ENC_OP1) && (crn == dbg_pkg::ENC_CRN) &&
              (op2 == dbg_pkg::ENC_OP2);
    sel_fa  = base_ok && (crm == dbg_pkg::ENC_CRM_FA);
    sel_xfr = base_ok && (crm == dbg_pkg::ENC_CRM_XFR);
    unknown = !sel_fa && !sel_xfr;
  end
endmodule

// File: rtl/dbg_fault_addr.sv
module dbg_fault_addr #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wp_hit,
  input  logic [AW-1:0] wp_pc,
  input  dbg_pkg::isa_e isa,
  input  logic          sw_we,
  input  logic [AW-1:0] sw_wdata,
  input  logic          dabort,
  input  logic          pabort,
  output logic [AW-1:0] fa_q
);
  localparam logic [AW-1:0] OFF_A32 = AW'(8);
  localparam logic [AW-1:0] OFF_T16 = AW'(4);

  logic [AW-1:0] offset;

  always_comb begin
    case (isa)
      dbg_pkg::ISA_A32: offset = OFF_A32;
      dbg_pkg::ISA_T16: offset = OFF_T16;
      default:          offset = '0;
    endcase
  end

  // Watchpoint capture outranks a software load; aborts have no path here.
  always_ff @(posedge clk) begin
    if (rst)         fa_q <= '0;
    else if (wp_hit) fa_q <= wp_pc + offset;
    else if (sw_we)  fa_q <= sw_wdata;
  end

  AST_A32_OFFSET: assert property (@(posedge clk) disable iff (rst)
    (wp_hit && isa == dbg_pkg::ISA_A32) |=> fa_q == $past(wp_pc) + AW'(8)); // R2
  AST_T16_OFFSET: assert property (@(posedge clk) disable iff (rst)
    (wp_hit && isa == dbg_pkg::ISA_T16) |=> fa_q == $past(wp_pc) + AW'(4)); // R3
  AST_ABORT_KEEP: assert property (@(posedge clk) disable iff (rst)
    ((dabort || pabort) && !wp_hit && !sw_we) |=> $stable(fa_q)); // R5
  AST_WP_WINS: assert property (@(posedge clk) disable iff (rst)
    (wp_hit && sw_we && isa == dbg_pkg::ISA_BC) |=> fa_q == $past(wp_pc)); // R8
endmodule

// File: rtl/dbg_xfer_chan.sv
module dbg_xfer_chan #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          prod_we,
  input  logic [DW-1:0] prod_data,
  input  logic          cons_re,
  output logic [DW-1:0] data_q,
  output logic          full_q
);
  logic accept;

  always_comb accept = prod_we && !full_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      if (accept)       full_q <= 1'b1;
      else if (cons_re) full_q <= 1'b0;
      if (accept) data_q <= prod_data;
    end
  end

  AST_SET_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    (prod_we && !full_q) |=> full_q); // R9
  AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (rst)
    (prod_we && full_q) |=> $stable(data_q)); // R11
  AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (rst)
    (cons_re && !prod_we) |=> !full_q); // R10
endmodule

// File: rtl/dbg_xfer_regs.sv
module dbg_xfer_regs #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wp_hit_i,
  input  logic [DW-1:0] wp_pc_i,
  input  logic [1:0]    isa_state_i,
  input  logic          dabort_i,
  input  logic          pabort_i,
  input  logic          priv_i,
  input  logic          cp_valid_i,
  input  logic          cp_read_i,
  input  logic [2:0]    cp_op1_i,
  input  logic [3:0]    cp_crn_i,
  input  logic [3:0]    cp_crm_i,
  input  logic [2:0]    cp_op2_i,
  input  logic [DW-1:0] cp_wdata_i,
  output logic          cp_ack_o,
  output logic          cp_undef_o,
  output logic [DW-1:0] cp_rdata_o,
  input  logic          ext_valid_i,
  input  logic          ext_write_i,
  input  logic [DW-1:0] ext_wdata_i,
  output logic          ext_ack_o,
  output logic [DW-1:0] ext_rdata_o,
  output logic          c2d_full_o,
  output logic          d2c_full_o
);
  logic          sel_fa, sel_xfr, unknown;
  logic          undef_now, fa_we, c2d_we, d2c_re, d2c_we, c2d_re;
  logic [DW-1:0] fa_q, c2d_q, d2c_q, rdata_nxt;

  dbg_cp_decode u_dec (
    .op1(cp_op1_i), .crn(cp_crn_i), .crm(cp_crm_i), .op2(cp_op2_i),
    .sel_fa(sel_fa), .sel_xfr(sel_xfr), .unknown(unknown)
  );

  always_comb begin
    undef_now = cp_valid_i && (unknown || (sel_fa && !priv_i));
    fa_we     = cp_valid_i && sel_fa && priv_i && !cp_read_i;
    c2d_we    = cp_valid_i && sel_xfr && !cp_read_i;
    d2c_re    = cp_valid_i && sel_xfr && cp_read_i;
    d2c_we    = ext_valid_i && ext_write_i;
    c2d_re    = ext_valid_i && !ext_write_i;
    rdata_nxt = '0;
    if (cp_valid_i && cp_read_i && !undef_now)
      rdata_nxt = sel_fa ? fa_q : d2c_q;
  end

  dbg_fault_addr #(.AW(DW)) u_fa (
    .clk(clk), .rst(rst), .wp_hit(wp_hit_i), .wp_pc(wp_pc_i),
    .isa(dbg_pkg::isa_e'(isa_state_i)), .sw_we(fa_we), .sw_wdata(cp_wdata_i),
    .dabort(dabort_i), .pabort(pabort_i), .fa_q(fa_q)
  );

  dbg_xfer_chan #(.DW(DW)) u_c2d (
    .clk(clk), .rst(rst), .prod_we(c2d_we), .prod_data(cp_wdata_i),
    .cons_re(c2d_re), .data_q(c2d_q), .full_q(c2d_full_o)
  );

  dbg_xfer_chan #(.DW(DW)) u_d2c (
    .clk(clk), .rst(rst), .prod_we(d2c_we), .prod_data(ext_wdata_i),
    .cons_re(d2c_re), .data_q(d2c_q), .full_q(d2c_full_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cp_ack_o    <= 1'b0;
      cp_undef_o  <= 1'b0;
      cp_rdata_o  <= '0;
      ext_ack_o   <= 1'b0;
      ext_rdata_o <= '0;
    end else begin
      cp_ack_o    <= cp_valid_i;
      cp_undef_o  <= undef_now;
      cp_rdata_o  <= rdata_nxt;
      ext_ack_o   <= ext_valid_i;
      ext_rdata_o <= c2d_re ? c2d_q : '0;
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!c2d_full_o && !d2c_full_o && fa_q == '0)); // R1
  AST_USER_UNDEF: assert property (@(posedge clk) disable iff (rst)
    (cp_valid_i && sel_fa && !priv_i) |=> (cp_undef_o && cp_ack_o)); // R7
  AST_UNKNOWN_UNDEF: assert property (@(posedge clk) disable iff (rst)
    (cp_valid_i && unknown) |=> (cp_undef_o && cp_rdata_o == '0)); // R12
endmodule

// File: tb/dbg_xfer_regs_bench.sv
module dbg_xfer_regs_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wp_hit_i = 0, dabort_i = 0, pabort_i = 0, priv_i = 1;
  logic [31:0] wp_pc_i = '0;
  logic [1:0]  isa_state_i = '0;
  logic        cp_valid_i = 0, cp_read_i = 0;
  logic [2:0]  cp_op1_i = '0, cp_op2_i = '0;
  logic [3:0]  cp_crn_i = '0, cp_crm_i = '0;
  logic [31:0] cp_wdata_i = '0;
  logic        cp_ack_o, cp_undef_o;
  logic [31:0] cp_rdata_o;
  logic        ext_valid_i = 0, ext_write_i = 0;
  logic [31:0] ext_wdata_i = '0;
  logic        ext_ack_o;
  logic [31:0] ext_rdata_o;
  logic        c2d_full_o, d2c_full_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #2.5 clk = ~clk;

  dbg_xfer_regs u_dbg_xfer_regs (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cp_op(input logic rd, input logic [3:0] crm, input logic [31:0] wd,
                       input logic priv);
    @(negedge clk);
    cp_valid_i = 1; cp_read_i = rd; cp_crm_i = crm; cp_wdata_i = wd; priv_i = priv;
    @(negedge clk);
    cp_valid_i = 0; priv_i = 1;
  endtask

  task automatic ext_op(input logic wr, input logic [31:0] wd);
    @(negedge clk);
    ext_valid_i = 1; ext_write_i = wr; ext_wdata_i = wd;
    @(negedge clk);
    ext_valid_i = 0;
  endtask

  task automatic watch(input logic [1:0] isa, input logic [31:0] pc);
    @(negedge clk);
    wp_hit_i = 1; isa_state_i = isa; wp_pc_i = pc;
    @(negedge clk);
    wp_hit_i = 0;
  endtask

  task automatic t_reset();
    chk("R1 c2d full", {31'b0, c2d_full_o}, 0);
    chk("R1 d2c full", {31'b0, d2c_full_o}, 0);
    cp_op(1, 4'd6, 0, 1);
    chk("R1 fault addr", cp_rdata_o, 0);
  endtask

  task automatic t_fa_rw();
    cp_op(0, 4'd6, 32'hCAFE_0010, 1);
    chk("R6 write ack", {31'b0, cp_ack_o}, 1);
    cp_op(1, 4'd6, 0, 1);
    chk("R6 readback", cp_rdata_o, 32'hCAFE_0010);
    chk("R6 no undef", {31'b0, cp_undef_o}, 0);
  endtask

  task automatic t_offsets();
    watch(2'd0, 32'h0000_1000);
    cp_op(1, 4'd6, 0, 1);
    chk("R2 a32 +8", cp_rdata_o, 32'h0000_1008);
    watch(2'd1, 32'h0000_2002);
    cp_op(1, 4'd6, 0, 1);
    chk("R3 t16 +4", cp_rdata_o, 32'h0000_2006);
    watch(2'd2, 32'h0000_3001);
    cp_op(1, 4'd6, 0, 1);
    chk("R4 bytecode +0", cp_rdata_o, 32'h0000_3001);
    watch(2'd0, 32'hFFFF_FFFC);
    cp_op(1, 4'd6, 0, 1);
    chk("R2 wrap", cp_rdata_o, 32'h0000_0004);
  endtask

  task automatic t_abort();
    @(negedge clk); dabort_i = 1;
    @(negedge clk); dabort_i = 0; pabort_i = 1;
    @(negedge clk); pabort_i = 0;
    cp_op(1, 4'd6, 0, 1);
    chk("R5 abort keeps", cp_rdata_o, 32'h0000_0004);
  endtask

  task automatic t_user();
    cp_op(0, 4'd6, 32'h1234_5678, 0);
    chk("R7 write undef", {31'b0, cp_undef_o}, 1);
    cp_op(1, 4'd6, 0, 0);
    chk("R7 read undef", {31'b0, cp_undef_o}, 1);
    chk("R7 read data", cp_rdata_o, 0);
    cp_op(1, 4'd6, 0, 1);
    chk("R7 unchanged", cp_rdata_o, 32'h0000_0004);
  endtask

  task automatic t_priority();
    @(negedge clk);
    wp_hit_i = 1; isa_state_i = 2'd1; wp_pc_i = 32'h0000_5000;
    cp_valid_i = 1; cp_read_i = 0; cp_crm_i = 4'd6; cp_wdata_i = 32'hDEAD_BEEF;
    @(negedge clk);
    wp_hit_i = 0; cp_valid_i = 0;
    cp_op(1, 4'd6, 0, 1);
    chk("R8 watchpoint wins", cp_rdata_o, 32'h0000_5004);
  endtask

  task automatic t_c2d();
    cp_op(0, 4'd5, 32'hA5A5_0001, 0);
    chk("R9 c2d full set", {31'b0, c2d_full_o}, 1);
    cp_op(0, 4'd5, 32'hBAD0_0002, 1);
    chk("R11 c2d still full", {31'b0, c2d_full_o}, 1);
    ext_op(0, 0);
    chk("R9 ext reads", ext_rdata_o, 32'hA5A5_0001);
    chk("R11 first kept", ext_rdata_o, 32'hA5A5_0001);
    chk("R9 c2d cleared", {31'b0, c2d_full_o}, 0);
  endtask

  task automatic t_d2c();
    ext_op(1, 32'h0F0F_1111);
    chk("R10 d2c full set", {31'b0, d2c_full_o}, 1);
    ext_op(1, 32'h0BAD_2222);
    cp_op(1, 4'd5, 0, 0);
    chk("R10 core reads", cp_rdata_o, 32'h0F0F_1111);
    chk("R11 d2c not overwritten", cp_rdata_o, 32'h0F0F_1111);
    chk("R10 d2c cleared", {31'b0, d2c_full_o}, 0);
  endtask

  task automatic t_unknown();
    @(negedge clk);
    cp_valid_i = 1; cp_read_i = 1; cp_crm_i = 4'd6; cp_op2_i = 3'd1;
    @(negedge clk);
    cp_valid_i = 0; cp_op2_i = 0;
    chk("R12 undef", {31'b0, cp_undef_o}, 1);
    chk("R12 data zero", cp_rdata_o, 0);
    @(negedge clk);
    cp_valid_i = 1; cp_read_i = 0; cp_crm_i = 4'd7; cp_wdata_i = 32'h7777_7777;
    @(negedge clk);
    cp_valid_i = 0;
    chk("R12 no flag", {31'b0, c2d_full_o}, 0);
    cp_op(1, 4'd6, 0, 1);
    chk("R12 fa unchanged", cp_rdata_o, 32'h0000_5004);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_fa_rw();
    t_offsets();
    t_abort();
    t_user();
    t_priority();
    t_c2d();
    t_d2c();
    t_unknown();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule